// File: doc/BRIEF.md
# Multiplexed Byte Bus Sequencer

This block runs single-byte transfers with a 16-bit address on a slow legacy host bus. It uses one shared 8-bit port and a small control code. Three control lines carry the current sequencer step. Outside the block, a 3-to-8 decoder turns that step into one-hot strobes for the address and data latches. Each latch captures the shared port when its step ends. For this reason the block keeps the port value steady for the whole step. A fourth control line selects a second address space. That space does not wait for the legacy bus, so every step there lasts a single clock.

A client starts work through a command interface. The command carries an operation code, a 16-bit address, a data byte, a beat count and a step length. The operations are single read, single write, sequential read, sequential write and atomic read-modify-write. The sequential and atomic operations do not reload the address. Instead they backtrack to an earlier data step, and the external address latch steps forward by itself. Read bytes come back with a one-cycle strobe. A done pulse closes every operation. The block does arbitration and interrupt polling only while it is idle.

The states and their codes on the control lines are IDLE (0), ADDR_LO (1), ADDR_HI (2), WR_DATA (3), WR_STROBE (4), RD_REQ (5), RD_DATA (6) and TURN (7). The transitions are:
- start: IDLE to ADDR_LO, when a command is accepted.
- address: ADDR_LO to ADDR_HI.
- write path: ADDR_HI to WR_DATA for writes.
- read path: ADDR_HI to RD_REQ for reads and read-modify-write.
- write commit: WR_DATA to WR_STROBE.
- write next: WR_STROBE back to WR_DATA, when more sequential beats remain.
- write finish: WR_STROBE to TURN.
- read capture: RD_REQ to RD_DATA.
- read next: RD_DATA back to RD_REQ, when more sequential beats remain.
- modify: RD_DATA to WR_DATA, for read-modify-write.
- read finish: RD_DATA to TURN.
- release: TURN to IDLE.

Top module: `mbb_seq`

## Requirements
- R1: `ctl[2:0]` carries the state code listed above. `ctl[3]` is 1 during a transfer in the fast space and 0 otherwise. Operation codes are: read 0, write 1, sequential read 2, sequential write 3, read-modify-write 4.
- R2: A single write passes through ADDR_LO, ADDR_HI, WR_DATA, WR_STROBE and TURN, then returns to IDLE. The port carries the address low byte in ADDR_LO, the high byte in ADDR_HI, and the data byte in WR_DATA and WR_STROBE. The port value holds steady within each state.
- R3: A single read passes through ADDR_LO, ADDR_HI, RD_REQ, RD_DATA and TURN. `bus_in` is sampled as the state leaves RD_DATA. `rd_valid` then pulses for one cycle with that byte on `rd_data`, and `rd_data` keeps the byte afterwards.
- R4: `bus_oe` is 0 in RD_REQ and RD_DATA and 1 in every other state, including IDLE. While `bus_oe` is 1 in IDLE and TURN, `bus_out` is 0.
- R5: In the host space each non-idle state lasts `step_cycles` clocks, sampled when the command is accepted. A value of 0 counts as 1.
- R6: In the fast space (`cmd_fast`=1) each non-idle state lasts exactly one clock, whatever `step_cycles` holds.
- R7: A sequential write makes `cmd_len`+1 beats by going from WR_STROBE back to WR_DATA. The address states run only once. On each entry to WR_DATA the byte on `cmd_wdata` is captured and `wdata_take` pulses on the next cycle.
- R8: A sequential read makes `cmd_len`+1 beats by going from RD_DATA back to RD_REQ, with one `rd_valid` pulse per beat. The address states run only once.
- R9: Read-modify-write goes from RD_DATA straight to WR_DATA and writes the read byte XOR the command's `cmd_wdata`. It reports the old byte on `rd_data` and does not pulse `wdata_take`.
- R10: `done` is a single-cycle pulse in the first IDLE cycle after TURN.
- R11: A command is accepted only in IDLE while `arb_gnt` is 1. While a command waits in IDLE, `arb_req` is 1. `bus_hold` is 1 from ADDR_LO until the return to IDLE.
- R12: In IDLE, `irq_seen` follows `irq_in` one cycle later. Outside IDLE it holds its value.
- R13: Operation codes 5 to 7 are ignored. The sequencer stays in IDLE and no done pulse follows.
- R14: After reset the state is IDLE: `ctl`=0, the port is driven with 0, and `done`, `rd_valid`, `bus_hold` and `irq_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command present |
| cmd_ready | output | 1 | command can be taken this cycle |
| cmd_op | input | 3 | operation code |
| cmd_addr | input | 16 | start address |
| cmd_wdata | input | 8 | write byte, or the XOR mask for read-modify-write |
| cmd_len | input | 4 | beats minus one for sequential operations |
| cmd_fast | input | 1 | select the fast address space |
| step_cycles | input | 4 | clocks per state in the host space |
| wdata_take | output | 1 | a write byte was captured |
| rd_valid | output | 1 | read byte strobe |
| rd_data | output | 8 | last byte read |
| done | output | 1 | operation complete |
| arb_req | output | 1 | request for the shared bus |
| arb_gnt | input | 1 | bus grant |
| bus_hold | output | 1 | bus held by this master |
| irq_in | input | 1 | interrupt line |
| irq_seen | output | 1 | polled interrupt level |
| ctl | output | 4 | control code, with the space select in the top bit |
| bus_out | output | 8 | shared port output value |
| bus_oe | output | 1 | shared port output enable |
| bus_in | input | 8 | shared port input value |

## Verification
A wrong state or a wrong transition shows up at once on `ctl`. The external latch model in the bench then loads the wrong latch or loads nothing. Within one operation this leaves a wrong byte in host memory, a wrong `rd_data`, or an extra or missing address load. A faulty dwell counter or beat counter changes how many clocks pass between acceptance and `done`, so every operation has its cycle count checked. A faulty port direction is caught in the very cycle it occurs, because the bench watches `bus_oe` against the state code on every clock.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    // State code driven on the control lines; decoded externally one-hot.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALO   = 3'd1,
        ST_AHI   = 3'd2,
        ST_WDAT  = 3'd3,
        ST_WSTB  = 3'd4,
        ST_RREQ  = 3'd5,
        ST_RDAT  = 3'd6,
        ST_TURN  = 3'd7
    } seq_state_e;

    localparam logic [2:0] OP_RD   = 3'd0;
    localparam logic [2:0] OP_WR   = 3'd1;
    localparam logic [2:0] OP_SRD  = 3'd2;
    localparam logic [2:0] OP_SWR  = 3'd3;
    localparam logic [2:0] OP_RMW  = 3'd4;
    localparam logic [2:0] OP_LAST = OP_RMW;

endpackage

// File: rtl/mbb_dwell.sv
module mbb_dwell #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

    AST_DWELL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0); // R5

endmodule

// File: rtl/mbb_portmux.sv
module mbb_portmux
    import mbb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  seq_state_e        state,
    input  logic              fast,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [3:0]        ctl,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              bus_hold
);

    always_comb begin
        bus_oe  = 1'b1;
        bus_out = '0;
        unique case (state)
            ST_ALO:           bus_out = addr[BYTE_W-1:0];
            ST_AHI:           bus_out = addr[ADDR_W-1:BYTE_W];
            ST_WDAT, ST_WSTB: bus_out = wbyte;
            ST_RREQ, ST_RDAT: bus_oe  = 1'b0;
            default:          bus_out = '0;
        endcase
    end

    assign bus_hold = (state != ST_IDLE);
    assign ctl      = {fast & bus_hold, state};

endmodule

// File: rtl/mbb_seq.sv
module mbb_seq
    import mbb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 4,
    parameter int STEP_W = 4,
    parameter bit ARB_EN = 1'b1,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_fast,
    input  logic [STEP_W-1:0] step_cycles,
    output logic              wdata_take,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              bus_hold,
    input  logic              irq_in,
    output logic              irq_seen,
    output logic [3:0]        ctl,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [BYTE_W-1:0] bus_in
);

    seq_state_e        state, state_nxt;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] mask_q, wreg_q, rd_q;
    logic [LEN_W-1:0]  beats_q;
    logic [STEP_W-1:0] hold_q, hold_new, hold_now;
    logic              fast_q, rd_valid_q, take_q, done_q, irq_q;
    logic              grant_ok, op_legal, go, expire, adv, wr_kind, more;

    assign grant_ok  = ARB_EN ? arb_gnt : 1'b1;
    assign op_legal  = (cmd_op <= OP_LAST);
    assign go        = cmd_valid && (state == ST_IDLE) && grant_ok && op_legal;
    assign cmd_ready = (state == ST_IDLE) && grant_ok;
    assign arb_req   = ARB_EN && cmd_valid && (state == ST_IDLE);
    assign adv       = (state == ST_IDLE) ? go : expire;
    assign wr_kind   = (op_q == OP_WR) || (op_q == OP_SWR);
    assign more      = (beats_q != '0);

    // Clocks per state minus one; fast space is always one clock.
    assign hold_new = (cmd_fast || step_cycles == '0) ? '0 : step_cycles - 1'b1;
    assign hold_now = go ? hold_new : hold_q;

    mbb_dwell #(.CNT_W(STEP_W)) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (hold_now),
        .expire   (expire)
    );

    // Next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (go) state_nxt = ST_ALO;
            ST_ALO:  state_nxt = ST_AHI;
            ST_AHI:  state_nxt = wr_kind ? ST_WDAT : ST_RREQ;
            ST_WDAT: state_nxt = ST_WSTB;
            ST_WSTB: state_nxt = (op_q == OP_SWR && more) ? ST_WDAT : ST_TURN;
            ST_RREQ: state_nxt = ST_RDAT;
            ST_RDAT: begin
                if (op_q == OP_RMW)              state_nxt = ST_WDAT;
                else if (op_q == OP_SRD && more) state_nxt = ST_RREQ;
                else                             state_nxt = ST_TURN;
            end
            ST_TURN: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (adv) begin
            state <= state_nxt;
        end
    end

    // Command capture and data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_RD;
            addr_q     <= '0;
            mask_q     <= '0;
            wreg_q     <= '0;
            rd_q       <= '0;
            beats_q    <= '0;
            hold_q     <= '0;
            fast_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            take_q     <= 1'b0;
            done_q     <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            take_q     <= 1'b0;
            done_q     <= 1'b0;
            if (state == ST_IDLE) begin
                irq_q <= irq_in;
            end
            if (go) begin
                op_q    <= cmd_op;
                addr_q  <= cmd_addr;
                mask_q  <= cmd_wdata;
                beats_q <= cmd_len;
                fast_q  <= cmd_fast;
                hold_q  <= hold_new;
            end
            if (adv && state != ST_IDLE) begin
                if (state_nxt == ST_WDAT) begin
                    if (state == ST_RDAT) begin
                        wreg_q <= bus_in ^ mask_q;
                    end else begin
                        wreg_q <= cmd_wdata;
                        take_q <= 1'b1;
                    end
                end
                if (state == ST_RDAT) begin
                    rd_q       <= bus_in;
                    rd_valid_q <= 1'b1;
                end
                if ((state == ST_WSTB && state_nxt == ST_WDAT) ||
                    (state == ST_RDAT && state_nxt == ST_RREQ)) begin
                    beats_q <= beats_q - 1'b1;
                end
                if (state == ST_TURN) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Output decode
    mbb_portmux #(.BYTE_W(BYTE_W)) u_portmux (
        .state    (state),
        .fast     (fast_q),
        .addr     (addr_q),
        .wbyte    (wreg_q),
        .ctl      (ctl),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .bus_hold (bus_hold)
    );

    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_q;
    assign wdata_take = take_q;
    assign done       = done_q;
    assign irq_seen   = irq_q;

    AST_READ_RELEASES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RREQ || state == ST_RDAT) |-> !bus_oe); // R4
    AST_PORT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == $past(state)) |-> $stable(bus_out)); // R2
    AST_DONE_FOLLOWS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_TURN); // R10
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> bus_hold); // R11
    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALO && $past(state) == ST_IDLE) |-> $past(grant_ok)); // R11
    AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_q && state != ST_IDLE) |=> state != $past(state)); // R6
    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && !op_legal) |=> state == ST_IDLE); // R13
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE) |-> $stable(irq_seen)); // R12

endmodule

// File: tb/mbb_seq_test.sv
module mbb_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_wdata;
    logic [7:0]  wd_drv = 8'h0;
    logic [3:0]  cmd_len = 4'd0;
    logic        cmd_fast = 1'b0;
    logic [3:0]  step_cycles = 4'd1;
    logic        wdata_take, rd_valid, done, arb_req, bus_hold, irq_seen, bus_oe;
    logic        arb_gnt = 1'b1;
    logic        irq_in = 1'b0;
    logic [7:0]  rd_data, bus_out, bus_in;
    logic [3:0]  ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side external latches and host memory
    logic [7:0] mem [0:255];
    logic [7:0] lat_lo = 8'h0;
    logic [7:0] lat_hi = 8'h0;
    logic [3:0] prev_ctl = 4'h0;
    logic [7:0] prev_out = 8'h0;
    int lo_loads = 0, hi_loads = 0, take_n = 0, take_base = 0, rd_n = 0, oe_bad = 0;
    logic [7:0] rd_log [0:31];
    logic seq_on = 1'b0;
    int total = 0, bad = 0;

    function automatic logic [7:0] seq_pick(input int i);
        case (i)
            0: seq_pick = 8'hA1;
            1: seq_pick = 8'hB2;
            2: seq_pick = 8'hC4;
            default: seq_pick = 8'h00;
        endcase
    endfunction

    assign cmd_wdata = seq_on ? seq_pick(take_n - take_base) : wd_drv;
    assign bus_in    = mem[lat_lo];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
            prev_ctl = 4'h0;
        end else begin
            if (ctl != prev_ctl) begin
                case (prev_ctl[2:0])
                    3'd1: begin lat_lo = prev_out; lo_loads++; end
                    3'd2: begin lat_hi = prev_out; hi_loads++; end
                    3'd4: begin
                        mem[lat_lo] = prev_out;
                        if (ctl[2:0] == 3'd3) lat_lo = lat_lo + 8'd1;
                    end
                    3'd6: if (ctl[2:0] == 3'd5) lat_lo = lat_lo + 8'd1;
                    default: ;
                endcase
            end
            if (((ctl[2:0] == 3'd5) || (ctl[2:0] == 3'd6)) == bus_oe) oe_bad++;
            if (rd_valid) begin rd_log[rd_n % 32] = rd_data; rd_n++; end
            if (wdata_take) take_n++;
            prev_ctl = ctl;
            prev_out = bus_out;
        end
    end

    mbb_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .cmd_fast(cmd_fast), .step_cycles(step_cycles), .wdata_take(wdata_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .arb_req(arb_req),
        .arb_gnt(arb_gnt), .bus_hold(bus_hold), .irq_in(irq_in), .irq_seen(irq_seen),
        .ctl(ctl), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    logic [3:0] first_ctl;

    task automatic issue(input logic [2:0] op, input logic [15:0] addr, input logic [7:0] wd,
                         input logic [3:0] len, input logic [3:0] steps, input logic fast);
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; wd_drv = wd; cmd_len = len;
        step_cycles = steps; cmd_fast = fast; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        first_ctl = ctl;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // {op[3], addr[16], wdata[8], steps[4], fast[1], exp_rd[8], exp_cycles[8]}
    localparam logic [47:0] VEC [0:5] = '{
        {3'd1, 16'h1210, 8'hC3, 4'd2, 1'b0, 8'h00, 8'd11},
        {3'd0, 16'h3410, 8'h00, 4'd0, 1'b0, 8'hC3, 8'd6},
        {3'd0, 16'h0020, 8'h00, 4'd3, 1'b0, 8'h7A, 8'd16},
        {3'd4, 16'h0010, 8'hFF, 4'd1, 1'b0, 8'hC3, 8'd8},
        {3'd0, 16'h0010, 8'h00, 4'd1, 1'b0, 8'h3C, 8'd6},
        {3'd1, 16'h0030, 8'h11, 4'd4, 1'b1, 8'h00, 8'd6}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, lo0, hi0, rd0, tk0, bad_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(ctl == 4'h0 && bus_oe && bus_out == 8'h0, "R14 ctl/port", {ctl, bus_out}, 0);
        chk(!done && !rd_valid && !bus_hold && !irq_seen && cmd_ready, "R14 flags",
            {done, rd_valid, bus_hold, irq_seen, cmd_ready}, 1);

        // Vector table: R2 R3 R5 R6 R9
        for (int v = 0; v < 6; v++) begin
            logic [47:0] e;
            e = VEC[v];
            issue(e[47:45], e[44:29], e[28:21], 4'd0, e[20:17], e[16]);
            chk(first_ctl == {e[16], 3'd1}, "R1 first ctl", first_ctl, {e[16], 3'd1});
            wait_done(cyc);
            chk(cyc == int'(e[7:0]), "R5/R6 cycles", cyc, e[7:0]);
            if (e[47:45] == 3'd1)
                chk(mem[e[36:29]] == e[28:21] && lat_hi == e[44:37], "R2 write",
                    {lat_hi, mem[e[36:29]]}, {e[44:37], e[28:21]});
            else
                chk(rd_data == e[15:8], "R3/R9 read", rd_data, e[15:8]);
            @(negedge clk);
            chk(!done, "R10 single pulse", done, 0);
        end
        chk(mem[8'h10] == 8'h3C, "R9 rmw written", mem[8'h10], 8'h3C);

        // R7 sequential write
        lo0 = lo_loads; hi0 = hi_loads; tk0 = take_n;
        take_base = take_n; seq_on = 1'b1;
        issue(3'd3, 16'h0040, 8'h00, 4'd2, 4'd1, 1'b0);
        wait_done(cyc);
        seq_on = 1'b0;
        chk(cyc == 10, "R7 cycles", cyc, 10);
        chk(mem[8'h40] == 8'hA1 && mem[8'h41] == 8'hB2 && mem[8'h42] == 8'hC4, "R7 data",
            {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'hA1B2C4);
        chk(take_n - tk0 == 3 && lo_loads - lo0 == 1 && hi_loads - hi0 == 1, "R7 beats",
            take_n - tk0, 3);

        // R8 sequential read
        lo0 = lo_loads; rd0 = rd_n; tk0 = take_n;
        issue(3'd2, 16'h0020, 8'h00, 4'd3, 4'd2, 1'b0);
        wait_done(cyc);
        chk(cyc == 23, "R8 cycles", cyc, 23);
        chk(rd_n - rd0 == 4 && lo_loads - lo0 == 1, "R8 beats", rd_n - rd0, 4);
        chk(rd_log[rd0 % 32] == 8'h7A && rd_log[(rd0+1) % 32] == 8'h7B &&
            rd_log[(rd0+2) % 32] == 8'h78 && rd_log[(rd0+3) % 32] == 8'h79, "R8 data",
            rd_log[(rd0+3) % 32], 8'h79);
        chk(take_n == tk0, "R9 no take on reads", take_n - tk0, 0);

        // R11 arbitration
        @(negedge clk);
        arb_gnt = 1'b0;
        cmd_op = 3'd0; cmd_addr = 16'h0010; cmd_fast = 1'b0; step_cycles = 4'd1;
        cmd_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(ctl == 4'h0 && arb_req && !cmd_ready, "R11 wait for grant",
            {ctl, arb_req, cmd_ready}, 8'h02);
        arb_gnt = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(ctl == 4'h1 && bus_hold && !arb_req, "R11 hold from ADDR_LO", {ctl, bus_hold}, 5'h03);
        wait_done(cyc);
        chk(!bus_hold && rd_data == 8'h3C, "R11 released", {bus_hold, rd_data}, 9'h03C);

        // R12 interrupt polling
        @(negedge clk);
        irq_in = 1'b1;
        @(negedge clk);
        chk(irq_seen, "R12 idle follow", irq_seen, 1);
        issue(3'd1, 16'h0050, 8'h77, 4'd0, 4'd2, 1'b0);
        irq_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(irq_seen, "R12 held in transfer", irq_seen, 1);
        wait_done(cyc);
        @(negedge clk);
        chk(!irq_seen, "R12 idle resume", irq_seen, 0);

        // R13 illegal operation codes
        bad_seen = 0;
        issue(3'd6, 16'h0060, 8'h00, 4'd0, 4'd1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            if (ctl != 4'h0 || done) bad_seen++;
            @(negedge clk);
        end
        chk(bad_seen == 0 && mem[8'h60] == (8'h60 ^ 8'h5A), "R13 ignored", bad_seen, 0);

        // R4 port direction monitor over the whole run
        chk(oe_bad == 0, "R4 port direction", oe_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule